// File: doc/BRIEF.md
# Programmable Pulse Time Sequencer

The sequencer drives one output line that rests low. It emits short high pulses of a fixed width at absolute tick counts that software chooses. Before a run, the host loads a list of event times into an internal table of up to 64 entries through a plain write port (address, data, write enable). On the start strobe, the host also supplies a pulse width and an entry count.

A one-shot run starts from a single-cycle start strobe. The sequence counter restarts at zero and advances once per clock. The counter is compared only with the current table entry. On a match a pulse is launched and the next entry becomes current. Entries that break the ordering rule are skipped, and a sticky error flag records this.

When every entry has been consumed and the last pulse has ended, the block drops busy, raises done and stops counting. Busy and done report the progress of a run. A later start strobe begins a fresh run from entry 0. Each pulse is fixed and short, and a whole run may span more than 21000 ticks. Arbitrary pulse trains therefore need no reprogramming of a periodic compare between events.

Top module: `pulse_seq_top`

## Requirements
- R1: `pulse_out` is low whenever no pulse is active: after reset, before a start, between pulses, and once `busy` is low.
- R2: The counter reads 0 in the cycle after the accepted start strobe and then increases by one each cycle. For an issued entry value E, `pulse_out` is high in exactly the cycles where the counter would read E+1 through E+W, with W the effective width.
- R3: The effective width W is `cfg_width`, sampled with the start strobe, for values 1 to 15. A `cfg_width` of 0 selects W = 8.
- R4: Table entry k is written at `wr_addr` = k. Entries 0 to `cfg_count`-1 (sampled at start) are consumed in increasing address order, and each valid entry yields exactly one pulse.
- R5: Two consecutive valid entries that are 20 ticks apart both produce their pulses, for any W up to 15.
- R6: The counter is 16 bits wide, so an entry of 21000 produces its pulse at the correct tick.
- R7: An entry is skipped without a pulse, and `seq_err` is set, if it is not greater than the last issued entry plus W. `seq_err` stays set until the next accepted start or reset.
- R8: Let L be the last issued entry. `done` rises, and `busy` falls, in the cycle where the counter would read L+W+2. With `cfg_count` = 0, `done` rises in the cycle where the counter would read 1.
- R9: An accepted start clears `done` and sets `busy` in the next cycle, and the run restarts from entry 0 with the counter at 0.
- R10: While `busy` is high, table writes and start strobes are ignored.
- R11: Synchronous active-high `rst` clears `busy`, `done`, `seq_err` and the counter, and forces `pulse_out` low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 6 | Table entry index |
| wr_data | input | 16 | Event time to store |
| cfg_width | input | 4 | Pulse width in cycles, 0 selects 8 |
| cfg_count | input | 7 | Number of entries to use, clamped to 64 |
| start | input | 1 | Single-cycle run trigger |
| pulse_out | output | 1 | Pulse output line |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| seq_err | output | 1 | Sticky flag for a skipped entry |

## Verification
Some properties are checked by assertions on every cycle. The line stays low when idle. Each high stretch lasts exactly the width latched at start. Busy and done never overlap, and done rises only as busy falls. An accepted start produces busy without done. The error flag cannot clear during a run. Reset forces everything quiet.

Other behaviour can only be shown by the directed scenarios, because it depends on table contents. These scenarios cover pulse placement at absolute ticks, the exact 20-tick gap, the long span near 21000, and skipping of out-of-order and too-close entries. They also show that writes and starts issued mid-run leave the stored table and the running sequence untouched.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int unsigned PST_DEF_WIDTH = 8;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_FIRE,
        EV_SKIP
    } pst_ev_e;
endpackage

// File: rtl/pst_table.sv
module pst_table #(
    parameter int TIME_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [TIME_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [TIME_W-1:0] rd_data
);
    logic [TIME_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (wr_en && !lock && (wr_addr == IDX_W'(k))) begin
                slot_q[k] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/pst_pulse.sv
module pst_pulse #(
    parameter int WIDTH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);
    logic [WIDTH_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (fire) begin
            rem_d = width;
        end else if (rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign active = (rem_q != '0);
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
    import pst_pkg::*;
#(
    parameter int TIME_W  = 16,
    parameter int DEPTH   = 64,
    parameter int WIDTH_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [TIME_W-1:0]  entry,
    input  logic               pulse_active,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               fire,
    output logic [WIDTH_W-1:0] width,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam logic [CNT_W-1:0]   DEPTH_V = CNT_W'(DEPTH);
    localparam logic [WIDTH_W-1:0] DEF_W   = WIDTH_W'(PST_DEF_WIDTH);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               err;
        logic [TIME_W-1:0]  cnt;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   total;
        logic [WIDTH_W-1:0] width;
        logic [TIME_W-1:0]  prev;
        logic               have_prev;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    pst_ev_e ev;
    logic [TIME_W-1:0] gap;
    logic [TIME_W-1:0] wide_w;

    always_comb begin
        st_d   = st_q;
        ev     = EV_IDLE;
        gap    = entry - st_q.prev;
        wide_w = TIME_W'(st_q.width);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy      = 1'b1;
                st_d.done      = 1'b0;
                st_d.err       = 1'b0;
                st_d.cnt       = '0;
                st_d.idx       = '0;
                st_d.prev      = '0;
                st_d.have_prev = 1'b0;
                st_d.width     = (cfg_width == '0) ? DEF_W : cfg_width;
                st_d.total     = (cfg_count > DEPTH_V) ? DEPTH_V : cfg_count;
            end
        end else begin
            if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.idx < st_q.total) begin
                if (st_q.have_prev && ((entry <= st_q.prev) || (gap <= wide_w))) begin
                    ev = EV_SKIP;
                end else if (entry < st_q.cnt) begin
                    ev = EV_SKIP;
                end else if (entry == st_q.cnt) begin
                    ev = EV_FIRE;
                end
                case (ev)
                    EV_FIRE: begin
                        st_d.idx       = st_q.idx + 1'b1;
                        st_d.prev      = entry;
                        st_d.have_prev = 1'b1;
                    end
                    EV_SKIP: begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.err = 1'b1;
                    end
                    default: ;
                endcase
            end else if (!pulse_active) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.idx[IDX_W-1:0];
    assign fire   = (ev == EV_FIRE);
    assign width  = st_q.width;
    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign err    = st_q.err;
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top #(
    parameter int TIME_W  = 16,
    parameter int DEPTH   = 64,
    parameter int WIDTH_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [TIME_W-1:0]  wr_data,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               start,
    output logic               pulse_out,
    output logic               busy,
    output logic               done,
    output logic               seq_err
);
    logic [IDX_W-1:0]   rd_idx;
    logic [TIME_W-1:0]  entry;
    logic               fire;
    logic [WIDTH_W-1:0] width;
    logic               active;

    pst_table #(.TIME_W(TIME_W), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .lock    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_idx),
        .rd_data (entry)
    );

    pst_ctrl #(.TIME_W(TIME_W), .DEPTH(DEPTH), .WIDTH_W(WIDTH_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_width    (cfg_width),
        .cfg_count    (cfg_count),
        .entry        (entry),
        .pulse_active (active),
        .rd_idx       (rd_idx),
        .fire         (fire),
        .width        (width),
        .busy         (busy),
        .done         (done),
        .err          (seq_err)
    );

    pst_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .width  (width),
        .active (active)
    );

    assign pulse_out = active;
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int WIDTH_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH_W-1:0] cfg_width,
    input logic               pulse_out,
    input logic               busy,
    input logic               done,
    input logic               seq_err
);
    logic [WIDTH_W:0] run_q;
    logic [WIDTH_W:0] wlat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            wlat_q <= (WIDTH_W+1)'(8);
        end else begin
            run_q <= pulse_out ? run_q + 1'b1 : '0;
            if (start && !busy) begin
                wlat_q <= (cfg_width == '0) ? (WIDTH_W+1)'(8) : {1'b0, cfg_width};
            end
        end
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !pulse_out);
    // R3
    width_exact_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && run_q != '0) |-> (run_q == wlat_q));
    // R3
    width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> (run_q < wlat_q));
    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $fell(busy));
    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_err && busy) |=> seq_err);
    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !seq_err && !pulse_out));
endmodule

bind pulse_seq_top pst_checker #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_width (cfg_width),
    .pulse_out (pulse_out),
    .busy      (busy),
    .done      (done),
    .seq_err   (seq_err)
);

// File: tb/sim_pulse_seq_top.sv
module sim_pulse_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int TIME_W = 16;
    localparam int DEPTH = 64;
    localparam int WIDTH_W = 4;
    localparam int IDX_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0] wr_addr = '0;
    logic [TIME_W-1:0] wr_data = '0;
    logic [WIDTH_W-1:0] cfg_width = '0;
    logic [IDX_W:0] cfg_count = '0;
    logic start = 1'b0;
    logic pulse_out, busy, done, seq_err;

    int checks = 0;
    int errors = 0;
    int exp_t [DEPTH];
    int exp_n = 0;

    pulse_seq_top #(.TIME_W(TIME_W), .DEPTH(DEPTH), .WIDTH_W(WIDTH_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_width(cfg_width), .cfg_count(cfg_count), .start(start),
        .pulse_out(pulse_out), .busy(busy), .done(done), .seq_err(seq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDX_W'(a); wr_data = TIME_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Runs one sequence; n counts cycles after the edge that takes start.
    task automatic run(input int cnt, input int wcfg, input int weff, input bit poke,
                       output int done_at, output int pulses, output int mism,
                       output bit err_seen);
        bit prev_p;
        int n;
        done_at = -1; pulses = 0; mism = 0; prev_p = 1'b0;
        cfg_count = (IDX_W+1)'(cnt); cfg_width = WIDTH_W'(wcfg);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R9 start sets busy, clears done", busy, 1);
        n = 0;
        while (n < 30000) begin
            bit e;
            e = 1'b0;
            for (int k = 0; k < exp_n; k++)
                if (n >= exp_t[k] + 1 && n <= exp_t[k] + weff) e = 1'b1;
            if (pulse_out !== e) mism++;
            if (pulse_out && !prev_p) pulses++;
            prev_p = pulse_out;
            if (done) begin
                done_at = n;
                break;
            end
            if (poke && n == 50) begin
                wr_en = 1'b1; wr_addr = 6'd1; wr_data = 16'd150; start = 1'b1;
            end else begin
                wr_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        wr_en = 1'b0; start = 1'b0;
        err_seen = seq_err;
    endtask

    task automatic t_reset;
        check(pulse_out === 1'b0, "R11 reset pulse_out", pulse_out, 0);
        check(busy === 1'b0, "R11 reset busy", busy, 0);
        check(done === 1'b0, "R11 reset done", done, 0);
        check(seq_err === 1'b0, "R11 reset seq_err", seq_err, 0);
    endtask

    task automatic t_basic;
        int da, p, m; bit er;
        wr(0, 5); wr(1, 40); wr(2, 60);
        exp_t[0] = 5; exp_t[1] = 40; exp_t[2] = 60; exp_n = 3;
        run(3, 0, 8, 1'b0, da, p, m, er);
        check(m == 0, "R2 R3 R5 waveform default width", m, 0);
        check(p == 3, "R4 pulse count", p, 3);
        check(da == 70, "R8 done timing", da, 70);
        check(er == 1'b0, "R7 no error on valid table", er, 0);
        check(busy === 1'b0 && pulse_out === 1'b0, "R1 idle after done", pulse_out, 0);
    endtask

    task automatic t_long;
        int da, p, m; bit er;
        wr(0, 0); wr(1, 20); wr(2, 100); wr(3, 21000);
        exp_t[0] = 0; exp_t[1] = 20; exp_t[2] = 100; exp_t[3] = 21000; exp_n = 4;
        run(4, 15, 15, 1'b0, da, p, m, er);
        check(m == 0, "R6 R5 waveform width 15", m, 0);
        check(p == 4, "R6 pulse count", p, 4);
        check(da == 21017, "R8 done after long span", da, 21017);
    endtask

    task automatic t_narrow;
        int da, p, m; bit er;
        wr(0, 3); wr(1, 5);
        exp_t[0] = 3; exp_t[1] = 5; exp_n = 2;
        run(2, 1, 1, 1'b0, da, p, m, er);
        check(m == 0, "R3 width 1 waveform", m, 0);
        check(p == 2, "R3 width 1 pulse count", p, 2);
    endtask

    task automatic t_skip;
        int da, p, m; bit er;
        wr(0, 10); wr(1, 30); wr(2, 25); wr(3, 35); wr(4, 60);
        exp_t[0] = 10; exp_t[1] = 30; exp_t[2] = 60; exp_n = 3;
        run(5, 8, 8, 1'b0, da, p, m, er);
        check(m == 0, "R7 waveform with skipped entries", m, 0);
        check(p == 3, "R7 pulse count after skips", p, 3);
        check(er == 1'b1, "R7 seq_err set", er, 1);
        check(da == 70, "R8 done after skips", da, 70);
    endtask

    task automatic t_busy_ignore;
        int da, p, m; bit er;
        wr(0, 100); wr(1, 200);
        exp_t[0] = 100; exp_t[1] = 200; exp_n = 2;
        run(2, 0, 8, 1'b1, da, p, m, er);
        check(m == 0, "R10 run unaffected by mid-run write/start", m, 0);
        check(da == 210, "R10 done timing unaffected", da, 210);
        check(er == 1'b0, "R9 start clears seq_err", er, 0);
        run(2, 0, 8, 1'b0, da, p, m, er);
        check(m == 0, "R10 table unchanged by write while busy", m, 0);
        check(p == 2, "R9 restart from entry 0", p, 2);
    endtask

    task automatic t_zero;
        int da, p, m; bit er;
        exp_n = 0;
        run(0, 0, 8, 1'b0, da, p, m, er);
        check(da == 1, "R8 empty run done timing", da, 1);
        check(p == 0, "R1 empty run no pulse", p, 0);
    endtask

    task automatic t_mid_reset;
        wr(0, 100);
        cfg_count = 7'd1; cfg_width = 4'd0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (102) @(negedge clk);
        check(pulse_out === 1'b1, "R2 pulse active before reset", pulse_out, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(pulse_out === 1'b0 && busy === 1'b0, "R11 mid-run reset", pulse_out, 0);
        check(done === 1'b0, "R11 mid-run reset done", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_long();
        t_narrow();
        t_skip();
        t_busy_ignore();
        t_zero();
        t_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule